// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small fully associative table of segment descriptors. Each slot holds an effective-segment word and a virtual-segment word. An address presented on the lookup port is compared against every slot at once, and the block returns the matching virtual-segment word. A slot matches at 256 MB granularity or at 1 TB granularity, as its own size field selects. A single command port carries the maintenance operations. These are a checked slot write, slot reads of either word, a find-by-address that returns all ones on a miss, invalidation of the one slot matching an address, and a bulk invalidation whose reach is set by a 3-bit hint.

Command results are registered. They come with an illegal-operation pulse, a warning pulse for a hint value that is tolerated but undefined, and local or global translation-cache flush requests for the cache that sits beyond this table. Two mode inputs select the newer architecture behaviour of bulk invalidation and 64-bit versus 32-bit addressing for find-by-address.

The block has no sequencing states. Every command completes at the clock edge that accepts it, and the lookup path is purely combinational.

Top module: `slb_array`

## Requirements
- R1: After reset every slot reads as zero, so no slot is valid. Lookup misses, and every pulse output and `rsp_valid` are low.
- R2: The segment-size field is VSID bits [63:62], with 00 for 256 MB and 01 for 1 TB. The valid flag is ESID bit 27. A slot hits when its ESID equals the address with bits [27:0] cleared and bit 27 set, and its size is 00. It also hits when its ESID equals the address with bits [39:0] cleared and bit 27 set, and its size is 01. On a hit, `lk_vsid` carries that slot's VSID word in the same cycle.
- R3: When several slots hit, the lowest-numbered slot supplies `lk_vsid`, the find result and the slot cleared by invalidate-by-address.
- R4: The command codes are 0 write, 1 read ESID, 2 read VSID, 3 find VSID, 4 invalidate-by-address local, 5 invalidate-by-address global and 6 invalidate-all. Code 7 is illegal. A read returns the slot's word with `rsp_valid` one cycle after the command. The slot number is `cmd_rb[11:0]`. A slot at or above the table size, or command code 7, gives an `err_pulse` and no response.
- R5: A write stores ESID = `cmd_rb` with bits [11:0] cleared and VSID = `cmd_rs`. It is rejected with `err_pulse`, leaving the table unchanged, in five cases: any of `cmd_rb[26:12]` is set; the size field is 10 or 11; the size field is 01 while 1 TB support is disabled; the page-size code `cmd_rs[6:4]` is not in the parameter list (default 0, 2, 5); the slot is out of range.
- R6: Invalidate-all clears the valid flag of slots 1 and up and keeps slot 0. This is the behaviour for hints 0, 1, 2 and 6 in the newer mode, and for every hint when `mode_v3` is low.
- R7: With `mode_v3` high, hint 7 clears nothing. Hints 3 and 4 also clear slot 0. Hint 3 keeps every slot whose class bit (VSID bit 7) is 0.
- R8: With `mode_v3` high, hint 5 acts as hint 0 and raises `warn_pulse` for one cycle.
- R9: Every invalidate-all raises `flush_local` for one cycle, whatever the hint.
- R10: Invalidate-by-address clears the valid flag of the matching slot. It then raises `flush_local` for code 4 or `flush_global` for code 5. With no match, nothing changes and no flush is raised.
- R11: Find VSID returns the matching VSID word, or all ones on a miss. When `mode_64bit` is low, the address is first reduced to its low 32 bits.
- R12: A write or invalidation takes effect at the clock edge that accepts the command. The lookup port sees the new contents immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_v3 | input | 1 | Newer architecture mode for invalidate-all hints |
| mode_64bit | input | 1 | 64-bit addressing for find VSID |
| lk_addr | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_vsid | output | 64 | VSID word of the winning slot, zero on a miss |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_hint | input | 3 | Invalidate-all hint |
| cmd_rb | input | 64 | Address or slot/ESID operand |
| cmd_rs | input | 64 | VSID operand for writes |
| rsp_valid | output | 1 | Read or find result valid |
| rsp_data | output | 64 | Read or find result |
| err_pulse | output | 1 | Illegal operation |
| warn_pulse | output | 1 | Undefined hint tolerated |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |

## Verification
Command outcomes (`rsp_valid`, `rsp_data`, `err_pulse`, `warn_pulse`, both flush requests) are due at the first rising edge after the command is presented, and they last one cycle. The bench therefore drives a command at a falling edge and samples these outputs at the next falling edge. The lookup port has no register, so its result is checked one time unit after the address changes, against a table model that already holds every earlier command's effect. Table contents after bulk or per-address invalidation are read back through slot reads rather than taken on trust.

// File: rtl/slb_pkg.sv
package slb_pkg;

    localparam int EA_W      = 64;
    localparam int SLOT_W    = 12;
    localparam int VALID_BIT = 27;
    localparam int CLASS_BIT = 7;
    localparam int LP_LO     = 4;
    localparam int LP_W      = 3;
    localparam int SIZE_LO   = 62;
    localparam int SIZE_HI   = 63;

    localparam logic [EA_W-1:0] SEG256_MASK = {36'hF_FFFF_FFFF, 28'h0};
    localparam logic [EA_W-1:0] SEG1T_MASK  = {24'hFF_FFFF, 40'h0};
    localparam logic [EA_W-1:0] VALID_MASK  = 64'h1 << VALID_BIT;

    typedef enum logic [2:0] {
        OP_WRITE      = 3'd0,
        OP_RD_ESID    = 3'd1,
        OP_RD_VSID    = 3'd2,
        OP_FIND_VSID  = 3'd3,
        OP_INV_ADDR   = 3'd4,
        OP_INV_ADDR_G = 3'd5,
        OP_INV_ALL    = 3'd6,
        OP_BAD        = 3'd7
    } slb_op_e;

    typedef enum logic [1:0] {
        SEG_256M = 2'b00,
        SEG_1T   = 2'b01
    } seg_size_e;

    typedef struct packed {
        logic [EA_W-1:0] esid;
        logic [EA_W-1:0] vsid;
    } slb_entry_t;

endpackage

// File: rtl/slb_entry_match.sv
module slb_entry_match
    import slb_pkg::*;
(
    input  logic [EA_W-1:0] esid,
    input  logic [1:0]      size,
    input  logic [EA_W-1:0] addr,
    output logic            hit
);
    logic [EA_W-1:0] key_256m;
    logic [EA_W-1:0] key_1t;

    always_comb begin
        key_256m = (addr & SEG256_MASK) | VALID_MASK;
        key_1t   = (addr & SEG1T_MASK)  | VALID_MASK;
        hit = ((esid == key_256m) && (size == SEG_256M)) ||
              ((esid == key_1t)   && (size == SEG_1T));
    end
endmodule

// File: rtl/slb_priority.sv
module slb_priority #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/slb_write_check.sv
module slb_write_check
    import slb_pkg::*;
#(
    parameter int                   NUM_PS     = 3,
    parameter logic [NUM_PS*LP_W-1:0] PS_CODES = 9'b101_010_000,
    parameter bit                   SUPPORT_1T = 1'b1
) (
    input  logic [VALID_BIT-SLOT_W-1:0] esid_rsvd,
    input  logic [1:0]                  size,
    input  logic [LP_W-1:0]             lp,
    output logic                        ok
);
    logic lp_known;
    logic size_ok;

    always_comb begin
        lp_known = 1'b0;
        for (int i = 0; i < NUM_PS; i++) begin
            if (lp == PS_CODES[i*LP_W +: LP_W]) lp_known = 1'b1;
        end
        size_ok = (size == SEG_256M) || ((size == SEG_1T) && SUPPORT_1T);
        ok = (esid_rsvd == '0) && size_ok && lp_known;
    end
endmodule

// File: rtl/slb_array.sv
module slb_array
    import slb_pkg::*;
#(
    parameter int                     NUM_ENTRIES = 32,
    parameter bit                     SUPPORT_1T  = 1'b1,
    parameter int                     NUM_PS      = 3,
    parameter logic [NUM_PS*LP_W-1:0] PS_CODES    = 9'b101_010_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_v3,
    input  logic            mode_64bit,
    input  logic [63:0]     lk_addr,
    output logic            lk_hit,
    output logic [63:0]     lk_vsid,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [2:0]      cmd_hint,
    input  logic [63:0]     cmd_rb,
    input  logic [63:0]     cmd_rs,
    output logic            rsp_valid,
    output logic [63:0]     rsp_data,
    output logic            err_pulse,
    output logic            warn_pulse,
    output logic            flush_local,
    output logic            flush_global
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    slb_entry_t tbl [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] lk_req;
    logic [NUM_ENTRIES-1:0] cmd_req;
    logic [NUM_ENTRIES-1:0] clr_all;
    logic [IDX_W-1:0]       lk_idx;
    logic [IDX_W-1:0]       cmd_idx;
    logic                   cmd_hit;
    logic [EA_W-1:0]        cmd_addr;
    logic [SLOT_W-1:0]      slot;
    logic [IDX_W-1:0]       slot_idx;
    logic                   slot_ok;
    logic                   wr_ok;
    slb_op_e                op;
    logic                   hint_from0;
    logic                   hint_class;
    logic                   hint_none;
    logic                   hint_warn;

    assign op       = slb_op_e'(cmd_op);
    assign cmd_addr = (op == OP_FIND_VSID && !mode_64bit) ? {32'h0, cmd_rb[31:0]} : cmd_rb;
    assign slot     = cmd_rb[SLOT_W-1:0];
    assign slot_idx = slot[IDX_W-1:0];
    assign slot_ok  = ({1'b0, slot} < (SLOT_W+1)'(NUM_ENTRIES));

    // Parallel comparators: one for the lookup port, one for the command port
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
        slb_entry_match u_lk (
            .esid (tbl[g].esid),
            .size (tbl[g].vsid[SIZE_HI:SIZE_LO]),
            .addr (lk_addr),
            .hit  (lk_req[g])
        );
        slb_entry_match u_cmd (
            .esid (tbl[g].esid),
            .size (tbl[g].vsid[SIZE_HI:SIZE_LO]),
            .addr (cmd_addr),
            .hit  (cmd_req[g])
        );
    end

    slb_priority #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_pri (
        .req (lk_req),
        .any (lk_hit),
        .idx (lk_idx)
    );

    slb_priority #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_cmd_pri (
        .req (cmd_req),
        .any (cmd_hit),
        .idx (cmd_idx)
    );

    assign lk_vsid = lk_hit ? tbl[lk_idx].vsid : '0;

    slb_write_check #(
        .NUM_PS     (NUM_PS),
        .PS_CODES   (PS_CODES),
        .SUPPORT_1T (SUPPORT_1T)
    ) u_wchk (
        .esid_rsvd (cmd_rb[VALID_BIT-1:SLOT_W]),
        .size      (cmd_rs[SIZE_HI:SIZE_LO]),
        .lp        (cmd_rs[LP_LO+LP_W-1:LP_LO]),
        .ok        (wr_ok)
    );

    // Hint decode for bulk invalidation
    always_comb begin
        hint_from0 = mode_v3 && (cmd_hint == 3'd3 || cmd_hint == 3'd4);
        hint_class = mode_v3 && (cmd_hint == 3'd3);
        hint_none  = mode_v3 && (cmd_hint == 3'd7);
        hint_warn  = mode_v3 && (cmd_hint == 3'd5);
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            clr_all[i] = tbl[i].esid[VALID_BIT] && !hint_none &&
                         ((i != 0) || hint_from0) &&
                         !(hint_class && !tbl[i].vsid[CLASS_BIT]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            err_pulse    <= 1'b0;
            warn_pulse   <= 1'b0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            rsp_valid    <= 1'b0;
            err_pulse    <= 1'b0;
            warn_pulse   <= 1'b0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
            if (cmd_valid) begin
                unique case (op)
                    OP_WRITE: begin
                        if (slot_ok && wr_ok) begin
                            tbl[slot_idx].esid <= {cmd_rb[EA_W-1:SLOT_W], {SLOT_W{1'b0}}};
                            tbl[slot_idx].vsid <= cmd_rs;
                        end else begin
                            err_pulse <= 1'b1;
                        end
                    end
                    OP_RD_ESID, OP_RD_VSID: begin
                        if (slot_ok) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= (op == OP_RD_ESID) ? tbl[slot_idx].esid
                                                            : tbl[slot_idx].vsid;
                        end else begin
                            err_pulse <= 1'b1;
                        end
                    end
                    OP_FIND_VSID: begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= cmd_hit ? tbl[cmd_idx].vsid : '1;
                    end
                    OP_INV_ADDR, OP_INV_ADDR_G: begin
                        if (cmd_hit) begin
                            tbl[cmd_idx].esid[VALID_BIT] <= 1'b0;
                            flush_local  <= (op == OP_INV_ADDR);
                            flush_global <= (op == OP_INV_ADDR_G);
                        end
                    end
                    OP_INV_ALL: begin
                        for (int i = 0; i < NUM_ENTRIES; i++) begin
                            if (clr_all[i]) tbl[i].esid[VALID_BIT] <= 1'b0;
                        end
                        flush_local <= 1'b1;
                        warn_pulse  <= hint_warn;
                    end
                    OP_BAD: begin
                        err_pulse <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R3
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_req & ~({NUM_ENTRIES{1'b1}} << lk_idx)) == '0));

    // R9
    inval_all_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INV_ALL) |=> flush_local);

    // R10
    inval_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_INV_ADDR || op == OP_INV_ADDR_G) && !cmd_hit)
        |=> (!flush_local && !flush_global));

    // R11
    find_miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_FIND_VSID && !cmd_hit) |=> (rsp_valid && rsp_data == '1));

    // R5
    bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_WRITE && !wr_ok) |=> err_pulse);

    // R6
    slot0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INV_ALL && !(mode_v3 && (cmd_hint == 3'd3 || cmd_hint == 3'd4)))
        |=> (tbl[0].esid[VALID_BIT] == $past(tbl[0].esid[VALID_BIT])));

    // R8
    warn_only_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op != OP_INV_ALL) |=> !warn_pulse);

    // R4
    err_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !rsp_valid);

endmodule

// File: tb/tb_slb_array.sv
module tb_slb_array;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam logic [63:0] M256 = {36'hF_FFFF_FFFF, 28'h0};
    localparam logic [63:0] M1T  = {24'hFF_FFFF, 40'h0};
    localparam logic [63:0] VB   = 64'h0000_0000_0800_0000;

    logic clk = 1'b0;
    logic rst_n;
    logic mode_v3, mode_64bit;
    logic [63:0] lk_addr;
    logic lk_hit;
    logic [63:0] lk_vsid;
    logic cmd_valid;
    logic [2:0] cmd_op, cmd_hint;
    logic [63:0] cmd_rb, cmd_rs;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic err_pulse, warn_pulse, flush_local, flush_global;

    logic d2_hit, d2_rv, d2_err, d2_warn, d2_fl, d2_fg;
    logic [63:0] d2_vsid, d2_rd;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_esid [N];
    logic [63:0] m_vsid [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    slb_array #(.NUM_ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .mode_v3(mode_v3), .mode_64bit(mode_64bit),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_vsid(lk_vsid),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_hint(cmd_hint),
        .cmd_rb(cmd_rb), .cmd_rs(cmd_rs), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .err_pulse(err_pulse), .warn_pulse(warn_pulse),
        .flush_local(flush_local), .flush_global(flush_global)
    );

    slb_array #(.NUM_ENTRIES(N), .SUPPORT_1T(1'b0)) dut_no1t (
        .clk(clk), .rst_n(rst_n), .mode_v3(mode_v3), .mode_64bit(mode_64bit),
        .lk_addr(lk_addr), .lk_hit(d2_hit), .lk_vsid(d2_vsid),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_hint(cmd_hint),
        .cmd_rb(cmd_rb), .cmd_rs(cmd_rs), .rsp_valid(d2_rv), .rsp_data(d2_rd),
        .err_pulse(d2_err), .warn_pulse(d2_warn),
        .flush_local(d2_fl), .flush_global(d2_fg)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int model_find(input logic [63:0] a);
        for (int i = 0; i < N; i++) begin
            if ((m_esid[i] == ((a & M256) | VB) && m_vsid[i][63:62] == 2'b00) ||
                (m_esid[i] == ((a & M1T) | VB) && m_vsid[i][63:62] == 2'b01))
                return i;
        end
        return -1;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [2:0] hint,
                          input logic [63:0] rb, input logic [63:0] rs, input string tag);
        logic e_rv = 0, e_err = 0, e_warn = 0, e_fl = 0, e_fg = 0;
        logic [63:0] e_rd = '0;
        int slot = int'(rb[11:0]);
        bit sok = slot < N;
        bit wr_legal;
        int k;
        logic [2:0] lp = rs[6:4];
        wr_legal = (rb[26:12] == 0) && (rs[63:62] <= 2'b01) && (lp == 0 || lp == 2 || lp == 5);
        case (op)
            3'd0: if (!sok || !wr_legal) e_err = 1;
                  else begin m_esid[slot] = {rb[63:12], 12'h0}; m_vsid[slot] = rs; end
            3'd1: if (!sok) e_err = 1; else begin e_rv = 1; e_rd = m_esid[slot]; end
            3'd2: if (!sok) e_err = 1; else begin e_rv = 1; e_rd = m_vsid[slot]; end
            3'd3: begin
                k = model_find(mode_64bit ? rb : {32'h0, rb[31:0]});
                e_rv = 1; e_rd = (k < 0) ? '1 : m_vsid[k];
            end
            3'd4, 3'd5: begin
                k = model_find(rb);
                if (k >= 0) begin
                    m_esid[k][27] = 1'b0;
                    e_fl = (op == 3'd4); e_fg = (op == 3'd5);
                end
            end
            3'd6: begin
                int start = 1;
                bit none = 0;
                e_fl = 1;
                if (mode_v3) begin
                    if (hint == 3'd7) none = 1;
                    if (hint == 3'd3 || hint == 3'd4) start = 0;
                    if (hint == 3'd5) e_warn = 1;
                end
                for (int i = start; i < N; i++) begin
                    if (!none && !(mode_v3 && hint == 3'd3 && !m_vsid[i][7]))
                        m_esid[i][27] = 1'b0;
                end
            end
            default: e_err = 1;
        endcase
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_hint = hint; cmd_rb = rb; cmd_rs = rs;
        @(negedge clk);
        cmd_valid = 0;
        chk(rsp_valid == e_rv, tag, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        if (e_rv) chk(rsp_data == e_rd, tag, "rsp_data", rsp_data, e_rd);
        chk(err_pulse == e_err, tag, "err_pulse", 64'(err_pulse), 64'(e_err));
        chk(warn_pulse == e_warn, (op == 3'd6) ? "R8" : tag, "warn_pulse", 64'(warn_pulse), 64'(e_warn));
        chk(flush_local == e_fl, (op == 3'd6) ? "R9" : tag, "flush_local", 64'(flush_local), 64'(e_fl));
        chk(flush_global == e_fg, tag, "flush_global", 64'(flush_global), 64'(e_fg));
    endtask

    task automatic chk_lookup(input logic [63:0] a, input string tag);
        int k;
        lk_addr = a;
        #1;
        k = model_find(a);
        chk(lk_hit == (k >= 0), tag, "lk_hit", 64'(lk_hit), 64'(k >= 0));
        chk(lk_vsid == ((k >= 0) ? m_vsid[k] : 64'h0), tag, "lk_vsid", lk_vsid,
            (k >= 0) ? m_vsid[k] : 64'h0);
    endtask

    function automatic logic [63:0] seg_base(input int i);
        if (i == 5) return 64'h0000_7700_0000_0000;
        if (i == 7) return 64'h0000_0000_3000_0000;
        return 64'h0000_0123_0000_0000 + (64'(i) << 28);
    endfunction

    function automatic logic [63:0] vsid_of(input int i);
        logic [2:0] lp = (i % 3 == 0) ? 3'd0 : (i % 3 == 1) ? 3'd2 : 3'd5;
        return (64'((i == 5) ? 1 : 0) << 62) | (64'(i + 1) << 12) |
               (64'(i & 1) << 7) | (64'(lp) << 4);
    endfunction

    task automatic fill(input bit check_1t);
        for (int i = 0; i < N; i++) begin
            run_op(3'd0, 3'd0, seg_base(i) | VB | 64'(i), vsid_of(i), "R12");
            if (check_1t)
                chk(d2_err == (i == 5), "R5", "1T write without support", 64'(d2_err), 64'(i == 5));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; mode_v3 = 0; mode_64bit = 1; lk_addr = '0;
        cmd_valid = 0; cmd_op = '0; cmd_hint = '0; cmd_rb = '0; cmd_rs = '0;
        for (int i = 0; i < N; i++) begin m_esid[i] = '0; m_vsid[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        chk(!rsp_valid && !err_pulse && !warn_pulse && !flush_local && !flush_global,
            "R1", "pulses after reset", 64'({rsp_valid, err_pulse, warn_pulse, flush_local, flush_global}), 64'h0);
        chk_lookup(64'h0, "R1");
        chk_lookup(seg_base(2), "R1");
        for (int i = 0; i < N; i++) run_op(3'd1, 3'd0, 64'(i), 64'h0, "R1");

        // R12 fill, then R2 lookups straight after the last write
        fill(1'b1);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < 4; j++) chk_lookup(seg_base(i) + 64'(j) * 64'h0123_4567, "R2");
        end
        for (int j = 0; j < 4; j++) chk_lookup(seg_base(5) + (64'(j) << 30) + 64'h55, "R2");
        chk_lookup(64'h0000_0123_0000_0000 + (64'(9) << 28), "R2");
        chk_lookup(64'h0000_7800_0000_0000, "R2");
        chk_lookup(64'hF000_0000_3000_0000, "R2");

        // R4 slot reads and illegal commands
        for (int i = 0; i < N; i++) begin
            run_op(3'd1, 3'd0, 64'(i), 64'h0, "R4");
            run_op(3'd2, 3'd0, 64'hABCD_0000 | 64'(i), 64'h0, "R4");
        end
        run_op(3'd1, 3'd0, 64'(N), 64'h0, "R4");
        run_op(3'd2, 3'd0, 64'hFFF, 64'h0, "R4");
        run_op(3'd7, 3'd0, 64'h0, 64'h0, "R4");

        // R5 rejected writes leave slot 1 unchanged
        run_op(3'd0, 3'd0, seg_base(1) | VB | 64'h1000 | 64'd1, 64'h0, "R5");
        run_op(3'd0, 3'd0, seg_base(1) | VB | 64'd1, 64'h8000_0000_0000_0000, "R5");
        run_op(3'd0, 3'd0, seg_base(1) | VB | 64'd1, 64'hC000_0000_0000_0000, "R5");
        run_op(3'd0, 3'd0, seg_base(1) | VB | 64'd1, 64'h10, "R5");
        run_op(3'd0, 3'd0, seg_base(1) | VB | 64'd8, 64'h0, "R5");
        run_op(3'd1, 3'd0, 64'd1, 64'h0, "R5");
        run_op(3'd2, 3'd0, 64'd1, 64'h0, "R5");

        // R11 find VSID, with 32-bit masking
        run_op(3'd3, 3'd0, seg_base(3) + 64'h777, 64'h0, "R11");
        run_op(3'd3, 3'd0, 64'h0000_0999_0000_0000, 64'h0, "R11");
        mode_64bit = 1;
        run_op(3'd3, 3'd0, 64'hFFFF_0000_3456_7890, 64'h0, "R11");
        mode_64bit = 0;
        run_op(3'd3, 3'd0, 64'hFFFF_0000_3456_7890, 64'h0, "R11");
        mode_64bit = 1;

        // R3 duplicate in slot 6 of slot 2's segment
        run_op(3'd0, 3'd0, seg_base(2) | VB | 64'd6, 64'h0000_0000_00AB_C020, "R3");
        chk_lookup(seg_base(2) + 64'h42, "R3");
        run_op(3'd3, 3'd0, seg_base(2), 64'h0, "R3");

        // R10 invalidate by address
        run_op(3'd4, 3'd0, seg_base(2) + 64'h10, 64'h0, "R10");
        run_op(3'd1, 3'd0, 64'd2, 64'h0, "R10");
        run_op(3'd1, 3'd0, 64'd6, 64'h0, "R10");
        chk_lookup(seg_base(2) + 64'h42, "R10");
        run_op(3'd5, 3'd0, seg_base(2), 64'h0, "R10");
        run_op(3'd4, 3'd0, seg_base(2), 64'h0, "R10");
        run_op(3'd5, 3'd0, seg_base(5) + 64'h1_0000_0000, 64'h0, "R10");
        chk_lookup(seg_base(5), "R10");

        // R6 R7 R8 R9 invalidate-all sweep over modes and hints
        for (int v = 0; v < 2; v++) begin
            for (int h = 0; h < 8; h++) begin
                string tg;
                mode_v3 = v[0];
                tg = (v == 1 && (h == 3 || h == 4 || h == 7)) ? "R7" :
                     (v == 1 && h == 5) ? "R8" : "R6";
                fill(1'b0);
                run_op(3'd6, 3'(h), 64'h0, 64'h0, tg);
                for (int i = 0; i < N; i++) run_op(3'd1, 3'd0, 64'(i), 64'h0, tg);
                chk_lookup(seg_base(0), tg);
                chk_lookup(seg_base(3), tg);
            end
        end

        summary();
        $finish;
    end
endmodule